// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog with a 24-bit down-counter. The counter is reloaded from a value built out of three reload byte registers. It counts down once per clock while enabled. When it reaches zero it reports a timeout and starts over.

A timeout during normal running raises a one-cycle system reset request. A timeout while the chip is in stop mode raises a one-cycle stop-mode recovery request instead. Both cases set sticky status flags, which software clears by writing ones to them.

The reload registers are protected against stray writes. A two-byte key must be written to the control address first. After the key, the upper, high and low reload bytes must follow in that exact order, with no other write in between. Any deviation closes the guard again. Refreshing the watchdog is done with a strobe input rather than a bus write.

Top module: `wdg_guard`

## Requirements
- R1: Writing 0x55 and then 0xAA to the control address (code 0) opens the guard. These two key writes leave both status flags unchanged.
- R2: Once the guard is open, writes to the upper (address 1), high (address 2) and low (address 3) reload bytes are accepted only in that order. The reload value is {upper, high, low}, visible on `reload_val`.
- R3: Any write that is not the next expected step while the guard is open or half open closes the guard. The write that broke the sequence is not stored into a reload byte, and no reload byte is accepted until a new sequence starts with 0x55.
- R4: While the first key byte has been seen, a control write of any value other than 0xAA closes the guard, including a second 0x55. A new sequence starts only when 0x55 is written in the closed state.
- R5: After the low byte is accepted, the guard closes by itself.
- R6: The counter loads the reload value on the first enabled cycle and on every refresh strobe while enabled. It decrements once per clock. It times out on the cycle after it holds zero, that is R+1 cycles after a load of R, and then reloads.
- R7: A timeout with `stop_mode` low gives a one-cycle `sys_rst_req` and sets the watchdog flag (control bit 7).
- R8: A timeout with `stop_mode` high gives a one-cycle `stop_recov_req` and no system reset request. It sets both the watchdog flag and the stop flag (control bit 6).
- R9: A control write that is not a key byte clears each flag whose bit (7 or 6) is one. A timeout in the same cycle takes priority.
- R10: A reload value of zero counts as the maximum count (2^24-1), so it never causes an early timeout.
- R11: After reset the guard is closed, the reload value is `RELOAD_RST`, and both flags and both requests are low.
- R12: While the enable is low the counter holds its value and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 upper, 2 high, 3 low |
| wr_data | input | 8 | Write data |
| wdt_enable | input | 1 | Watchdog run enable |
| refresh | input | 1 | Refresh strobe, reloads the counter |
| stop_mode | input | 1 | Chip is in stop mode |
| sys_rst_req | output | 1 | One-cycle system reset request |
| stop_recov_req | output | 1 | One-cycle stop-mode recovery request |
| flag_wdt | output | 1 | Sticky watchdog timeout flag |
| flag_stop | output | 1 | Sticky timeout-in-stop flag |
| reload_val | output | 24 | Current reload value {upper, high, low} |

## Verification
The bench keeps `BYTE_W` at 8, so the full 24-bit counter and the three-byte ordering are exercised. It sets `RELOAD_RST` to 20. Reload values written through the guarded sequence, mostly 8, bring timeouts within tens of cycles, so the exact timeout cycle of each period can be predicted and compared. A zero reload maps to a count of about sixteen million, so for that case only the absence of an early timeout is within reach.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int ADDR_W   = 2;
    localparam int RL_BYTES = 3;

    localparam logic [ADDR_W-1:0] A_CTL = 2'd0;
    localparam logic [ADDR_W-1:0] A_RLU = 2'd1;
    localparam logic [ADDR_W-1:0] A_RLH = 2'd2;
    localparam logic [ADDR_W-1:0] A_RLL = 2'd3;

    typedef enum logic [2:0] {
        LK_SHUT,
        LK_HALF,
        LK_OPEN_U,
        LK_OPEN_H,
        LK_OPEN_L
    } lock_e;
endpackage

// File: rtl/wdg_lock.sv
module wdg_lock
    import wdg_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h55,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hAA
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                key_hit,
    output logic [RL_BYTES-1:0] rl_acc
);
    typedef struct packed {
        lock_e st;
    } lock_t;

    lock_t lock_d, lock_q;
    logic  ctl_wr;

    always_comb begin
        lock_d  = lock_q;
        key_hit = 1'b0;
        rl_acc  = '0;
        ctl_wr  = (wr_addr == A_CTL);
        if (wr_en) begin
            lock_d.st = LK_SHUT;
            case (lock_q.st)
                LK_SHUT: if (ctl_wr && wr_data == KEY_FIRST) begin
                    lock_d.st = LK_HALF;
                    key_hit   = 1'b1;
                end
                LK_HALF: if (ctl_wr && wr_data == KEY_SECOND) begin
                    lock_d.st = LK_OPEN_U;
                    key_hit   = 1'b1;
                end
                LK_OPEN_U: if (wr_addr == A_RLU) begin
                    lock_d.st = LK_OPEN_H;
                    rl_acc[2] = 1'b1;
                end
                LK_OPEN_H: if (wr_addr == A_RLH) begin
                    lock_d.st = LK_OPEN_L;
                    rl_acc[1] = 1'b1;
                end
                LK_OPEN_L: if (wr_addr == A_RLL) begin
                    rl_acc[0] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= '{st: LK_SHUT};
        else        lock_q <= lock_d;
    end

    // R5: the low byte always ends the sequence
    p_shut_after_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q.st == LK_OPEN_L && wr_en) |=> lock_q.st == LK_SHUT);

    // R1: the second key byte opens the guard for the upper byte
    p_key_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q.st == LK_HALF && wr_en && wr_addr == A_CTL && wr_data == KEY_SECOND)
        |=> lock_q.st == LK_OPEN_U);

    // R3: a closed guard accepts no reload byte
    p_closed_rejects_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q.st == LK_SHUT || lock_q.st == LK_HALF) |-> rl_acc == '0);
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             refresh,
    input  logic [CNT_W-1:0] reload,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run_seen;
    } cnt_t;

    cnt_t             cnt_d, cnt_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val       = (reload == '0) ? '1 : reload;
        cnt_d          = cnt_q;
        expire         = 1'b0;
        cnt_d.run_seen = run;
        if (run) begin
            if (!cnt_q.run_seen || refresh) begin
                cnt_d.cnt = load_val;
            end else if (cnt_q.cnt == '0) begin
                expire    = 1'b1;
                cnt_d.cnt = load_val;
            end else begin
                cnt_d.cnt = cnt_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: a refresh while running loads the effective reload value
    p_refresh_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && refresh) |=> cnt_q.cnt == $past(load_val));

    // R6: steady running counts down by one
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q.run_seen && !refresh && cnt_q.cnt != '0)
        |=> cnt_q.cnt == $past(cnt_q.cnt) - 1'b1);

    // R12: a stopped counter holds
    p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q.cnt));

    // R10: the load value is never zero
    p_no_zero_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> load_val != '0);
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int                           BYTE_W     = 8,
    parameter logic [RL_BYTES*BYTE_W-1:0]   RELOAD_RST = 'h400
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]            wr_data,
    input  logic                         wdt_enable,
    input  logic                         refresh,
    input  logic                         stop_mode,
    output logic                         sys_rst_req,
    output logic                         stop_recov_req,
    output logic                         flag_wdt,
    output logic                         flag_stop,
    output logic [RL_BYTES*BYTE_W-1:0]   reload_val
);
    localparam int CNT_W     = RL_BYTES * BYTE_W;
    localparam int BIT_WDT   = BYTE_W - 1;
    localparam int BIT_STOP  = BYTE_W - 2;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             f_wdt;
        logic             f_stop;
        logic             rst_req;
        logic             rec_req;
    } top_t;

    top_t                top_d, top_q;
    logic                key_hit;
    logic [RL_BYTES-1:0] rl_acc;
    logic                expire;
    logic                plain_ctl;

    wdg_lock #(
        .DATA_W    (BYTE_W),
        .KEY_FIRST (BYTE_W'('h55)),
        .KEY_SECOND(BYTE_W'('hAA))
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .key_hit(key_hit),
        .rl_acc (rl_acc)
    );

    wdg_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wdt_enable),
        .refresh(refresh),
        .reload (top_q.reload),
        .expire (expire)
    );

    always_comb begin
        top_d     = top_q;
        plain_ctl = wr_en && (wr_addr == A_CTL) && !key_hit;
        for (int b = 0; b < RL_BYTES; b++) begin
            if (rl_acc[b]) top_d.reload[b*BYTE_W +: BYTE_W] = wr_data;
        end
        if (plain_ctl) begin
            if (wr_data[BIT_WDT])  top_d.f_wdt  = 1'b0;
            if (wr_data[BIT_STOP]) top_d.f_stop = 1'b0;
        end
        top_d.rst_req = expire && !stop_mode;
        top_d.rec_req = expire && stop_mode;
        if (expire) begin
            top_d.f_wdt = 1'b1;
            if (stop_mode) top_d.f_stop = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{reload: RELOAD_RST, default: '0};
        else        top_q <= top_d;
    end

    assign sys_rst_req    = top_q.rst_req;
    assign stop_recov_req = top_q.rec_req;
    assign flag_wdt       = top_q.f_wdt;
    assign flag_stop      = top_q.f_stop;
    assign reload_val     = top_q.reload;

    // R8: the two requests never coincide
    p_one_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_rst_req && stop_recov_req));

    // R7: a reset request lasts one cycle
    p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    // R7: the watchdog flag accompanies a reset request
    p_flag_with_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> flag_wdt);

    // R8: both flags accompany a recovery request
    p_flags_with_recov_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_recov_req |-> (flag_wdt && flag_stop));

    // R1: key writes never clear a flag
    p_key_keeps_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |=> (!$fell(flag_wdt) && !$fell(flag_stop)));

    // R3: the reload value only moves after a write to a reload address
    p_reload_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reload_val) |-> $past(wr_en && wr_addr != A_CTL));
endmodule

// File: tb/wdg_guard_tb.sv
module wdg_guard_tb;
    localparam logic [23:0] RST_RL = 24'd20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wdt_enable = 1'b0;
    logic        refresh = 1'b0;
    logic        stop_mode = 1'b0;
    logic        sys_rst_req, stop_recov_req, flag_wdt, flag_stop;
    logic [23:0] reload_val;

    int    n_cmp = 0;
    int    n_bad = 0;
    longint cyc = 0;
    bit    done = 1'b0;

    typedef struct {
        int     kind;
        longint at;
        string  tag;
    } exp_t;
    exp_t exp_q[$];

    wdg_guard #(.BYTE_W(8), .RELOAD_RST(RST_RL)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wdt_enable(wdt_enable), .refresh(refresh),
        .stop_mode(stop_mode), .sys_rst_req(sys_rst_req),
        .stop_recov_req(stop_recov_req), .flag_wdt(flag_wdt),
        .flag_stop(flag_stop), .reload_val(reload_val)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops predicted timeout events and compares kind and cycle
    always @(negedge clk) begin
        if (rst_n && !done && (sys_rst_req || stop_recov_req)) begin
            int k;
            exp_t e;
            k = (sys_rst_req ? 1 : 0) + (stop_recov_req ? 2 : 0);
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R12: actual request kind %0d at %0d expected none", k, cyc);
            end else begin
                e = exp_q.pop_front();
                chk({e.tag, " kind"}, k, e.kind);
                chk({e.tag, " cycle"}, cyc, e.at);
            end
        end
    end

    task automatic push(int kind, longint at, string tag);
        exp_t e;
        e.kind = kind; e.at = at; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic bus_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_until(longint t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        longint c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reload", reload_val, RST_RL);
        chk("R11 flags", {flag_wdt, flag_stop}, 0);
        chk("R11 requests", {sys_rst_req, stop_recov_req}, 0);

        // full sequence with distinct bytes
        bus_wr(0, 8'h55); bus_wr(0, 8'hAA);
        bus_wr(1, 8'h12); bus_wr(2, 8'h34); bus_wr(3, 8'h56);
        chk("R2 byte order", reload_val, 24'h123456);
        chk("R1 flags kept", {flag_wdt, flag_stop}, 0);
        bus_wr(1, 8'h99);
        chk("R5 relock after low", reload_val, 24'h123456);

        // foreign write after first key
        bus_wr(0, 8'h55); bus_wr(2, 8'h01); bus_wr(0, 8'hAA); bus_wr(1, 8'h77);
        chk("R3 foreign write after key", reload_val, 24'h123456);
        // out of order after full key
        bus_wr(0, 8'h55); bus_wr(0, 8'hAA); bus_wr(2, 8'h99); bus_wr(1, 8'h77);
        chk("R3 out of order", reload_val, 24'h123456);
        // repeated first key
        bus_wr(0, 8'h55); bus_wr(0, 8'h55); bus_wr(0, 8'hAA); bus_wr(1, 8'h77);
        chk("R4 double first key", reload_val, 24'h123456);
        // wrong second key
        bus_wr(0, 8'h55); bus_wr(0, 8'h3C); bus_wr(0, 8'hAA); bus_wr(1, 8'h77);
        chk("R4 wrong second key", reload_val, 24'h123456);
        // broken after upper
        bus_wr(0, 8'h55); bus_wr(0, 8'hAA); bus_wr(1, 8'h01);
        bus_wr(0, 8'h00); bus_wr(2, 8'h02);
        chk("R3 partial sequence", reload_val, 24'h013456);

        // reload of 8
        bus_wr(0, 8'h55); bus_wr(0, 8'hAA);
        bus_wr(1, 8'h00); bus_wr(2, 8'h00); bus_wr(3, 8'h08);
        chk("R2 reload 8", reload_val, 24'd8);

        // R6/R7: enable, two periods
        @(negedge clk);
        wdt_enable = 1'b1; c = cyc;
        push(1, c + 10, "R6 first timeout");
        push(1, c + 19, "R7 second timeout");
        wait_until(c + 20);
        wdt_enable = 1'b0;
        @(negedge clk);
        chk("R7 wdt flag", flag_wdt, 1);
        chk("R7 stop flag clear", flag_stop, 0);

        // R12: disabled for a while, nothing expected
        repeat (30) @(negedge clk);
        chk("R12 no pending", exp_q.size(), 0);

        // R6: re-enable loads, then refreshes keep it quiet
        wdt_enable = 1'b1; c = cyc;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            refresh = 1'b1; c = cyc;
            @(negedge clk);
            refresh = 1'b0;
            repeat (3) @(negedge clk);
        end
        push(1, c + 10, "R6 after last refresh");
        wait_until(c + 12);
        wdt_enable = 1'b0;
        @(negedge clk);
        chk("R6 refresh events consumed", exp_q.size(), 0);

        // R9: clear watchdog flag
        bus_wr(0, 8'h80);
        chk("R9 clear wdt", flag_wdt, 0);

        // R8: timeout in stop mode
        @(negedge clk);
        stop_mode = 1'b1; wdt_enable = 1'b1; c = cyc;
        push(2, c + 10, "R8 stop timeout");
        wait_until(c + 12);
        wdt_enable = 1'b0; stop_mode = 1'b0;
        @(negedge clk);
        chk("R8 flags", {flag_wdt, flag_stop}, 3);

        // R1: key writes keep flags; R9: plain write clears selectively
        bus_wr(0, 8'h55);
        chk("R1 first key keeps flags", {flag_wdt, flag_stop}, 3);
        bus_wr(0, 8'hAA);
        chk("R1 second key keeps flags", {flag_wdt, flag_stop}, 3);
        bus_wr(0, 8'h80);
        chk("R9 clear only wdt", {flag_wdt, flag_stop}, 1);
        bus_wr(1, 8'h44);
        chk("R3 control write closed guard", reload_val, 24'd8);
        bus_wr(0, 8'h40);
        chk("R9 clear stop", flag_stop, 0);

        // R10: zero reload
        bus_wr(0, 8'h55); bus_wr(0, 8'hAA);
        bus_wr(1, 8'h00); bus_wr(2, 8'h00); bus_wr(3, 8'h00);
        chk("R10 reload zero stored", reload_val, 0);
        wdt_enable = 1'b1;
        repeat (300) @(negedge clk);
        wdt_enable = 1'b0;
        chk("R10 no early timeout", flag_wdt, 0);
        chk("R10 queue empty", exp_q.size(), 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule